// File: doc/BRIEF.md
# Mini-Context Register Remap and Trap Gate

This block sits in the decode stage of a multithreaded core. Each hardware context of the core carries two mini-contexts, and both mini-contexts use the same 32-entry architectural register set of their context. For each decoded instruction, the block rewrites the three register specifiers into renaming-table indices. The index is the context number followed by the specifier. When the context runs in split mode, the specifier's top bit is replaced by the mini-context's own partition bit, so one mini-context lives in the low half of the set and the other lives in the high half. Code built for the low half therefore runs unchanged on either mini-context.

The block also decides which mini-contexts may issue. In shared mode the kernel uses the full register set, so only one mini-context of a context may be inside the kernel at a time. A trap taken by one mini-context blocks its sibling and latches both program counters and both mini-context IDs for the handler. The sibling is released when the trapping mini-context returns to user mode. A blocked instruction is stalled and never dropped. If both mini-contexts trap in the same cycle, mini-context 0 wins. The losing trap is remembered and signalled for replay when the sibling is released. In split mode no blocking takes place.

Top module: `mt_remap_gate`

## Requirements
- R1: After reset, every context is in shared mode with both partition bits 0, no mini-context is blocked, no context has a kernel owner, and no replay pulse is raised.
- R2: In shared mode each renaming index equals {context, specifier}, with the 5-bit specifier unchanged (register 31 stays 31).
- R3: In split mode each renaming index equals {context, p, specifier[3:0]}, where p is the partition bit of the decoding mini-context (p=0 maps register 31 to 15, p=1 maps register 5 to 21).
- R4: A write with cfg_we=1 sets split mode (cfg_split) and both partition bits (cfg_pbit[m] for mini-context m) of context cfg_ctx. The write takes effect from the next cycle and leaves other contexts unchanged.
- R5: In shared mode with no kernel owner, a trap request from mini-context m makes m the owner from the next cycle. At the same moment its sibling is blocked, hold_trap_pc and hold_sib_pc latch the current PCs of m and of the sibling, and kern_id=m, sib_id=1-m.
- R6: A valid instruction from a blocked mini-context gives dec_stall=1 and out_issue=0. A valid instruction from an unblocked mini-context gives out_issue=1 and dec_stall=0. Mini-context k of context c is bit 2c+k of every per-mini vector.
- R7: A return-to-user from the owner clears ownership and unblocks the sibling in the next cycle. A return-to-user from the blocked sibling changes nothing.
- R8: When both mini-contexts of a shared-mode context request a trap in the same cycle, mini-context 0 becomes owner and mini-context 1 is blocked. On release, replay of mini-context 1 pulses for exactly one cycle, in the cycle where it is unblocked.
- R9: A trap request from the blocked sibling while an owner is active is held pending and gets the same one-cycle replay pulse on release.
- R10: In split mode, trap requests cause no blocking and no ownership, and the latched PCs keep their values.
- R11: A trap request from the current owner leaves ownership, blocking and the latched PCs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write the per-context mode control |
| cfg_ctx | input | CTX_W | Context being written |
| cfg_split | input | 1 | 1 selects split mode |
| cfg_pbit | input | 2 | Partition bits, bit m for mini-context m |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_ctx | input | CTX_W | Context of the instruction |
| dec_mini | input | 1 | Mini-context of the instruction |
| dec_rs1 | input | REG_W | First source specifier |
| dec_rs2 | input | REG_W | Second source specifier |
| dec_rd | input | REG_W | Destination specifier |
| trap_req | input | 2*NUM_CTX | Trap request per mini-context |
| ret_user | input | 2*NUM_CTX | Return to user mode per mini-context |
| mini_pc | input | 2*NUM_CTX*PC_W | Current PC per mini-context |
| ren_rs1 | output | CTX_W+REG_W | Renaming index for rs1 |
| ren_rs2 | output | CTX_W+REG_W | Renaming index for rs2 |
| ren_rd | output | CTX_W+REG_W | Renaming index for rd |
| out_issue | output | 1 | Instruction may proceed |
| dec_stall | output | 1 | Instruction held: its mini-context is blocked |
| mini_blocked | output | 2*NUM_CTX | Blocked flag per mini-context |
| replay | output | 2*NUM_CTX | One-cycle pulse: re-raise the lost trap |
| kern_own | output | NUM_CTX | Context has a mini-context in the kernel |
| kern_id | output | NUM_CTX | Latched ID of the trapping mini-context |
| sib_id | output | NUM_CTX | Latched ID of the blocked sibling |
| hold_trap_pc | output | NUM_CTX*PC_W | Latched PC of the trapping mini-context |
| hold_sib_pc | output | NUM_CTX*PC_W | Latched PC of the blocked sibling |

## Verification
The remap is swept over every specifier value, every context, both mini-contexts and all five mode settings: shared mode, plus split mode with each pair of partition bits. Three different specifier patterns go on the three ports at once. This separates a missing top-bit override, a bit taken from the wrong mini-context, a port crossover, and a mode leaking between contexts. The trap gate is exercised with single traps from each side, simultaneous traps, a late trap from the blocked sibling, a repeated trap from the owner, a return from the wrong mini-context, and traps in split mode. Each of these patterns shows a different mistake in the arbitration, release or replay order.

// File: rtl/mt_pkg.sv
`timescale 1ns/1ps
package mt_pkg;
   localparam int unsigned MINI_PER_CTX = 2;

   typedef struct packed {
      logic       split;
      logic [1:0] pbit;
   } ctx_cfg_t;
endpackage

// File: rtl/mt_spec_remap.sv
`timescale 1ns/1ps
module mt_spec_remap #(
   parameter int unsigned REG_W = 5
) (
   input  logic [REG_W-1:0] spec_in,
   input  logic             split,
   input  logic             pbit,
   output logic [REG_W-1:0] spec_out
);
   // Split mode overrides the top specifier bit; the zero register is not special-cased.
   always_comb begin
      if (split) spec_out = {pbit, spec_in[REG_W-2:0]};
      else       spec_out = spec_in;
   end
endmodule

// File: rtl/mt_ctx_gate.sv
`timescale 1ns/1ps
module mt_ctx_gate #(
   parameter int unsigned PC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            split,
   input  logic [1:0]      trap_req,
   input  logic [1:0]      ret_user,
   input  logic [PC_W-1:0] pc0,
   input  logic [PC_W-1:0] pc1,
   output logic            own,
   output logic            own_id,
   output logic [1:0]      blocked,
   output logic [1:0]      replay,
   output logic [PC_W-1:0] trap_pc,
   output logic [PC_W-1:0] sib_pc
);
   logic own_q, id_q, pend_q;
   logic [1:0] replay_q;
   logic [PC_W-1:0] tpc_q, spc_q;
   logic take, win, lose_now, late_sib, release_now, rep_any;

   always_comb begin
      take        = !split && !own_q && (trap_req != 2'b00);
      win         = !trap_req[0];
      lose_now    = take && (trap_req == 2'b11);
      late_sib    = own_q && trap_req[!id_q];
      release_now = own_q && ret_user[id_q];
      rep_any     = pend_q || late_sib;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_q    <= 1'b0;
         id_q     <= 1'b0;
         pend_q   <= 1'b0;
         replay_q <= 2'b00;
         tpc_q    <= '0;
         spc_q    <= '0;
      end else begin
         replay_q <= 2'b00;
         if (take) begin
            own_q  <= 1'b1;
            id_q   <= win;
            pend_q <= lose_now;
            tpc_q  <= win ? pc1 : pc0;
            spc_q  <= win ? pc0 : pc1;
         end else if (release_now) begin
            own_q    <= 1'b0;
            pend_q   <= 1'b0;
            replay_q <= rep_any ? (id_q ? 2'b01 : 2'b10) : 2'b00;
         end else if (late_sib) begin
            pend_q <= 1'b1;
         end
      end
   end

   assign own     = own_q;
   assign own_id  = id_q;
   assign blocked = own_q ? (id_q ? 2'b01 : 2'b10) : 2'b00;
   assign replay  = replay_q;
   assign trap_pc = tpc_q;
   assign sib_pc  = spc_q;
endmodule

// File: rtl/mt_remap_gate.sv
`timescale 1ns/1ps
module mt_remap_gate #(
   parameter int unsigned NUM_CTX = 4,
   parameter int unsigned REG_W   = 5,
   parameter int unsigned PC_W    = 16,
   localparam int unsigned CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
   localparam int unsigned IDX_W  = CTX_W + REG_W,
   localparam int unsigned NMINI  = NUM_CTX * mt_pkg::MINI_PER_CTX
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [CTX_W-1:0]      cfg_ctx,
   input  logic                  cfg_split,
   input  logic [1:0]            cfg_pbit,
   input  logic                  dec_valid,
   input  logic [CTX_W-1:0]      dec_ctx,
   input  logic                  dec_mini,
   input  logic [REG_W-1:0]      dec_rs1,
   input  logic [REG_W-1:0]      dec_rs2,
   input  logic [REG_W-1:0]      dec_rd,
   input  logic [NMINI-1:0]      trap_req,
   input  logic [NMINI-1:0]      ret_user,
   input  logic [NMINI*PC_W-1:0] mini_pc,
   output logic [IDX_W-1:0]      ren_rs1,
   output logic [IDX_W-1:0]      ren_rs2,
   output logic [IDX_W-1:0]      ren_rd,
   output logic                  out_issue,
   output logic                  dec_stall,
   output logic [NMINI-1:0]      mini_blocked,
   output logic [NMINI-1:0]      replay,
   output logic [NUM_CTX-1:0]    kern_own,
   output logic [NUM_CTX-1:0]    kern_id,
   output logic [NUM_CTX-1:0]    sib_id,
   output logic [NUM_CTX*PC_W-1:0] hold_trap_pc,
   output logic [NUM_CTX*PC_W-1:0] hold_sib_pc
);
   import mt_pkg::*;

   generate
      if (NUM_CTX < 2 || (1 << CTX_W) != NUM_CTX) begin : g_bad_ctx
         $error("NUM_CTX must be a power of two and at least 2");
      end
      if (REG_W < 2) begin : g_bad_reg
         $error("REG_W must be at least 2");
      end
      if (PC_W < 1) begin : g_bad_pc
         $error("PC_W must be at least 1");
      end
   endgenerate

   ctx_cfg_t           cfg_q [NUM_CTX];
   logic [NUM_CTX-1:0] part_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CTX; i++) cfg_q[i] <= '0;
      end else if (cfg_we) begin
         cfg_q[cfg_ctx] <= '{split: cfg_split, pbit: cfg_pbit};
      end
   end

   // Per-context trap gate
   genvar c;
   generate
      for (c = 0; c < NUM_CTX; c++) begin : g_ctx
         logic ownb, idb;
         assign part_vec[c] = cfg_q[c].split;
         mt_ctx_gate #(.PC_W(PC_W)) u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .split    (cfg_q[c].split),
            .trap_req (trap_req[2*c +: 2]),
            .ret_user (ret_user[2*c +: 2]),
            .pc0      (mini_pc[(2*c)*PC_W +: PC_W]),
            .pc1      (mini_pc[(2*c+1)*PC_W +: PC_W]),
            .own      (ownb),
            .own_id   (idb),
            .blocked  (mini_blocked[2*c +: 2]),
            .replay   (replay[2*c +: 2]),
            .trap_pc  (hold_trap_pc[c*PC_W +: PC_W]),
            .sib_pc   (hold_sib_pc[c*PC_W +: PC_W])
         );
         assign kern_own[c] = ownb;
         assign kern_id[c]  = idb;
         assign sib_id[c]   = !idb;
      end
   endgenerate

   // Specifier remap, one lane per register port
   logic             sel_split, sel_pbit;
   logic [REG_W-1:0] spec_in  [3];
   logic [REG_W-1:0] spec_out [3];

   assign sel_split  = cfg_q[dec_ctx].split;
   assign sel_pbit   = cfg_q[dec_ctx].pbit[dec_mini];
   assign spec_in[0] = dec_rs1;
   assign spec_in[1] = dec_rs2;
   assign spec_in[2] = dec_rd;

   genvar k;
   generate
      for (k = 0; k < 3; k++) begin : g_lane
         mt_spec_remap #(.REG_W(REG_W)) u_remap (
            .spec_in  (spec_in[k]),
            .split    (sel_split),
            .pbit     (sel_pbit),
            .spec_out (spec_out[k])
         );
      end
   endgenerate

   assign ren_rs1 = {dec_ctx, spec_out[0]};
   assign ren_rs2 = {dec_ctx, spec_out[1]};
   assign ren_rd  = {dec_ctx, spec_out[2]};

   logic sel_blk;
   assign sel_blk   = mini_blocked[{dec_ctx, dec_mini}];
   assign out_issue = dec_valid && !sel_blk;
   assign dec_stall = dec_valid && sel_blk;
endmodule

// File: rtl/mt_remap_gate_chk.sv
`timescale 1ns/1ps
module mt_remap_gate_chk #(
   parameter int unsigned NUM_CTX = 4,
   localparam int unsigned NMINI  = NUM_CTX * 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_we,
   input logic [NUM_CTX-1:0] part_vec,
   input logic [NMINI-1:0]   trap_req,
   input logic [NMINI-1:0]   ret_user,
   input logic [NMINI-1:0]   mini_blocked,
   input logic [NMINI-1:0]   replay,
   input logic [NUM_CTX-1:0] kern_own,
   input logic [NUM_CTX-1:0] kern_id,
   input logic               out_issue,
   input logic               dec_stall
);
   assert_issue_xor_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_issue && dec_stall));

   genvar c;
   generate
      for (c = 0; c < NUM_CTX; c++) begin : g_c
         assert_one_side_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(mini_blocked[2*c] && mini_blocked[2*c+1]));

         assert_trap_blocks_sib_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!part_vec[c] && !kern_own[c] && trap_req[2*c]) |=> mini_blocked[2*c+1]);

         assert_return_unblocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (kern_own[c] && ret_user[2*c + kern_id[c]])
               |=> (!mini_blocked[2*c] && !mini_blocked[2*c+1]));

         assert_split_never_owns_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (part_vec[c] && !kern_own[c] && !cfg_we) |=> !kern_own[c]);

         assert_replay_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (replay[2*c] || replay[2*c+1]) |-> ($past(kern_own[c]) && !kern_own[c]));
      end
   endgenerate
endmodule

bind mt_remap_gate mt_remap_gate_chk #(.NUM_CTX(NUM_CTX)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .part_vec     (part_vec),
   .trap_req     (trap_req),
   .ret_user     (ret_user),
   .mini_blocked (mini_blocked),
   .replay       (replay),
   .kern_own     (kern_own),
   .kern_id      (kern_id),
   .out_issue    (out_issue),
   .dec_stall    (dec_stall)
);

// File: tb/sim_mt_remap_gate.sv
`timescale 1ns/1ps
module sim_mt_remap_gate;
   localparam int NC = 2;
   localparam int RW = 5;
   localparam int PW = 16;
   localparam int CW = 1;
   localparam int IW = CW + RW;
   localparam int NM = NC * 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [CW-1:0] cfg_ctx = '0;
   logic cfg_split = 1'b0;
   logic [1:0] cfg_pbit = '0;
   logic dec_valid = 1'b0;
   logic [CW-1:0] dec_ctx = '0;
   logic dec_mini = 1'b0;
   logic [RW-1:0] dec_rs1 = '0, dec_rs2 = '0, dec_rd = '0;
   logic [NM-1:0] trap_req = '0, ret_user = '0;
   logic [NM*PW-1:0] mini_pc = '0;
   logic [IW-1:0] ren_rs1, ren_rs2, ren_rd;
   logic out_issue, dec_stall;
   logic [NM-1:0] mini_blocked, replay;
   logic [NC-1:0] kern_own, kern_id, sib_id;
   logic [NC*PW-1:0] hold_trap_pc, hold_sib_pc;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mt_remap_gate #(.NUM_CTX(NC), .REG_W(RW), .PC_W(PW)) u0 (.*);

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic write_cfg(input int c, input bit s, input logic [1:0] pb);
      cfg_we = 1'b1; cfg_ctx = c[CW-1:0]; cfg_split = s; cfg_pbit = pb;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic set_pc(input int idx, input int v);
      mini_pc[idx*PW +: PW] = v[PW-1:0];
   endtask

   function automatic int exp_idx(input int c, input bit s, input bit p, input int spec);
      int v;
      v = s ? (p * 16 + (spec % 16)) : spec;
      return c * 32 + v;
   endfunction

   initial begin
      #200000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 blocked", int'(mini_blocked), 0);
      chk("R1 owner", int'(kern_own), 0);
      chk("R1 replay", int'(replay), 0);
      dec_valid = 1'b1; dec_ctx = 1; dec_mini = 1; dec_rs1 = 31; #1;
      chk("R1 pass-through", int'(ren_rs1), 32 + 31);
      chk("R1 issue", int'(out_issue), 1);

      // R2/R3/R4: exhaustive remap sweep
      for (int c = 0; c < NC; c++) begin
         for (int mode = 0; mode < 5; mode++) begin
            bit s = (mode != 0);
            logic [1:0] pb = (mode == 0) ? 2'b00 : 2'(mode - 1);
            write_cfg(c, s, pb);
            for (int m = 0; m < 2; m++) begin
               for (int sp = 0; sp < 32; sp++) begin
                  dec_ctx = c[CW-1:0]; dec_mini = m[0];
                  dec_rs1 = sp[RW-1:0];
                  dec_rs2 = 5'(sp ^ 31);
                  dec_rd  = 5'((sp + 7) % 32);
                  #1;
                  chk(s ? "R3 rs1" : "R2 rs1", int'(ren_rs1), exp_idx(c, s, pb[m], sp));
                  chk(s ? "R3 rs2" : "R2 rs2", int'(ren_rs2), exp_idx(c, s, pb[m], sp ^ 31));
                  chk(s ? "R3 rd" : "R2 rd", int'(ren_rd), exp_idx(c, s, pb[m], (sp + 7) % 32));
               end
            end
            write_cfg(c, 1'b0, 2'b00);
         end
      end
      // R4: a write to context 1 leaves context 0 alone
      write_cfg(1, 1'b1, 2'b00);
      dec_ctx = 0; dec_mini = 0; dec_rs1 = 31; #1;
      chk("R4 other ctx", int'(ren_rs1), 31);
      dec_ctx = 1; #1;
      chk("R4 written ctx", int'(ren_rs1), 32 + 15);
      write_cfg(1, 1'b0, 2'b00);

      // R5: ctx0 mini1 traps
      set_pc(0, 16'h1234); set_pc(1, 16'h5678);
      trap_req = 4'b0010; step(); trap_req = '0;
      chk("R5 owner", int'(kern_own), 1);
      chk("R5 blocked", int'(mini_blocked), 4'b0001);
      chk("R5 trap pc", int'(hold_trap_pc[0 +: PW]), 16'h5678);
      chk("R5 sib pc", int'(hold_sib_pc[0 +: PW]), 16'h1234);
      chk("R5 ids", int'({kern_id[0], sib_id[0]}), 2'b10);
      // R6: issue gating
      dec_ctx = 0; dec_mini = 0; #1;
      chk("R6 stall blocked", int'({dec_stall, out_issue}), 2'b10);
      dec_mini = 1; #1;
      chk("R6 owner issues", int'({dec_stall, out_issue}), 2'b01);
      dec_ctx = 1; dec_mini = 0; #1;
      chk("R6 other ctx issues", int'({dec_stall, out_issue}), 2'b01);
      // R11: owner traps again
      set_pc(0, 16'haaaa); set_pc(1, 16'hbbbb);
      trap_req = 4'b0010; step(); trap_req = '0;
      chk("R11 blocked", int'(mini_blocked), 4'b0001);
      chk("R11 trap pc", int'(hold_trap_pc[0 +: PW]), 16'h5678);
      // R7: return from wrong side ignored, then from owner
      ret_user = 4'b0001; step(); ret_user = '0;
      chk("R7 wrong return", int'(mini_blocked), 4'b0001);
      ret_user = 4'b0010; step(); ret_user = '0;
      chk("R7 released", int'({kern_own, mini_blocked}), 0);
      chk("R7 no replay", int'(replay), 0);

      // R8: simultaneous traps on ctx0
      set_pc(0, 16'h0a0a); set_pc(1, 16'h0b0b);
      trap_req = 4'b0011; step(); trap_req = '0;
      chk("R8 winner id", int'(kern_id[0]), 0);
      chk("R8 loser blocked", int'(mini_blocked), 4'b0010);
      chk("R8 trap pc", int'(hold_trap_pc[0 +: PW]), 16'h0a0a);
      chk("R8 no early replay", int'(replay), 0);
      ret_user = 4'b0001; step(); ret_user = '0;
      chk("R8 replay pulse", int'(replay), 4'b0010);
      chk("R8 unblocked", int'(mini_blocked), 0);
      step();
      chk("R8 pulse one cycle", int'(replay), 0);

      // R9: late trap from blocked sibling on ctx1
      set_pc(2, 16'h2222); set_pc(3, 16'h3333);
      trap_req = 4'b0100; step(); trap_req = '0;
      chk("R9 owner ctx1", int'(kern_own), 2'b10);
      trap_req = 4'b1000; step(); trap_req = '0;
      chk("R9 owner kept", int'(kern_id[1]), 0);
      chk("R9 trap pc kept", int'(hold_trap_pc[PW +: PW]), 16'h2222);
      ret_user = 4'b0100; step(); ret_user = '0;
      chk("R9 replay pulse", int'(replay), 4'b1000);

      // R10: split mode ignores traps
      write_cfg(1, 1'b1, 2'b10);
      set_pc(2, 16'h7777);
      trap_req = 4'b1100; step(); trap_req = '0;
      chk("R10 no owner", int'(kern_own), 0);
      chk("R10 no block", int'(mini_blocked), 0);
      chk("R10 pc kept", int'(hold_trap_pc[PW +: PW]), 16'h2222);
      chk("R10 no replay", int'(replay), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule